// File: doc/BRIEF.md
# Masked Interrupt Cause Controller

This block collects up to 32 level-sensitive interrupt requests into a single line toward an upstream cascade controller. Each cycle in which a request input is high sets the matching bit of a cause register. An enable mask register gates the cause bits. The AND of cause and mask forms the pending set. One registered output, the OR of the pending set, signals the upstream controller.

Software sees two 32-bit registers through a plain write/read port. The cause register sits at byte offset 0x00. Writing ones there acknowledges the lines whose bits are one. The mask register sits at offset 0x04 and reads back exactly as written. As a convenience, a status output gives the number of the lowest pending line, together with a valid flag, so a handler does not have to scan the bits itself. To quiesce the block, software writes zero to the mask register and all-ones to the cause register while the sources are low.

Top module: `irq_cause_hub`

## Requirements
- R1: While reset is active, and right after it is released, the cause and mask registers read zero, `irq_out` is 0 and `pend_valid` is 0.
- R2: If `src_level[n]` is high in a cycle, bit n of the cause register is 1 after the next clock edge. The register is read at byte offset 0x00.
- R3: A write to offset 0x00 clears each cause bit whose data bit is 1, at the next edge, provided that line's source is low. Cause bits written with 0 keep their value.
- R4: If a write-one clear and a high source hit the same bit in the same cycle, the bit stays 1.
- R5: A write to offset 0x04 stores the whole data word in the mask register at the next edge. A read at 0x04 returns that word unchanged. A mask bit of 1 enables its line.
- R6: `pend_valid` is 1 exactly when (cause AND mask) is non-zero, taken from the current register contents.
- R7: When `pend_valid` is 1, `pend_idx` is the index of the lowest-numbered set bit of (cause AND mask).
- R8: `irq_out` equals the OR of (cause AND mask) as it stood one clock earlier.
- R9: With all sources low, writing 0 to the mask and then all-ones to the cause leaves `pend_valid` at 0, and `irq_out` at 0 from the following cycle on.
- R10: Reads at any offset other than 0x00 and 0x04 return zero. Writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | 32 | Level request per line, bit n belongs to line n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the accessed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, valid in the same cycle |
| irq_out | output | 1 | Combined interrupt toward the upstream controller |
| pend_idx | output | 5 | Lowest pending line number |
| pend_valid | output | 1 | At least one line is pending |

## Verification
Two functions can land on the same cause bit in one cycle: the acknowledge write, which clears the bit, and the level source, which sets it. The bench forces this collision on purpose by writing all-ones to the cause register while chosen sources are held high. It also causes the collision at random, by drawing the write data and the sparse source patterns independently. The bench judges the outcome against a model in which the set always takes precedence over the clear. It compares the read-back cause word, the pending index and the delayed output against that model.

// File: rtl/icc_pkg.sv
package icc_pkg;
   parameter int ICC_OFF_CAUSE = 0;
   parameter int ICC_OFF_MASK  = 4;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CAUSE = 2'd1,
      SEL_MASK  = 2'd2
   } icc_sel_e;
endpackage

// File: rtl/icc_decode.sv
module icc_decode
   import icc_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [NUM_LINES-1:0] cause_q,
   input  logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] clr_vec,
   output logic                 mask_we,
   output logic [DATA_W-1:0]    rd_data
);
   icc_sel_e sel;

   always_comb begin
      if (addr == ADDR_W'(ICC_OFF_CAUSE))     sel = SEL_CAUSE;
      else if (addr == ADDR_W'(ICC_OFF_MASK)) sel = SEL_MASK;
      else                                    sel = SEL_NONE;
   end

   // acknowledge vector: ones in the write word clear cause bits
   assign clr_vec = (wr_en && sel == SEL_CAUSE) ? wr_data[NUM_LINES-1:0] : '0;
   assign mask_we = wr_en && (sel == SEL_MASK);

   always_comb begin
      unique case (sel)
         SEL_CAUSE: rd_data = DATA_W'(cause_q);
         SEL_MASK:  rd_data = DATA_W'(mask_q);
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/icc_regs.sv
module icc_regs #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] src_level,
   input  logic [NUM_LINES-1:0] clr_vec,
   input  logic                 mask_we,
   input  logic [NUM_LINES-1:0] mask_wd,
   output logic [NUM_LINES-1:0] cause_q,
   output logic [NUM_LINES-1:0] mask_q
);
   // per-line cause flop: a set from the source beats an acknowledge
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n)            cause_q[i] <= 1'b0;
         else if (src_level[i]) cause_q[i] <= 1'b1;
         else if (clr_vec[i])   cause_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_wd;
   end
endmodule

// File: rtl/icc_prio.sv
module icc_prio #(
   parameter int NUM_LINES = 32,
   parameter int IDX_W     = 5
) (
   input  logic [NUM_LINES-1:0] pend,
   output logic [IDX_W-1:0]     idx,
   output logic                 valid
);
   // scan from the top so the lowest set bit is written last and wins
   always_comb begin
      idx = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end

   assign valid = |pend;
endmodule

// File: rtl/irq_cause_hub.sv
module irq_cause_hub #(
   parameter int NUM_LINES = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter bit OUT_REG   = 1'b1,
   localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] src_level,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 irq_out,
   output logic [IDX_W-1:0]     pend_idx,
   output logic                 pend_valid
);
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("irq_cause_hub: NUM_LINES must lie in 1..DATA_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("irq_cause_hub: ADDR_W too small to reach offset 4");
   end

   logic [NUM_LINES-1:0] cause_q;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] clr_vec;
   logic                 mask_we;
   logic [NUM_LINES-1:0] pend;

   icc_decode #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cause_q (cause_q),
      .mask_q  (mask_q),
      .clr_vec (clr_vec),
      .mask_we (mask_we),
      .rd_data (rd_data)
   );

   icc_regs #(.NUM_LINES(NUM_LINES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_level (src_level),
      .clr_vec   (clr_vec),
      .mask_we   (mask_we),
      .mask_wd   (wr_data[NUM_LINES-1:0]),
      .cause_q   (cause_q),
      .mask_q    (mask_q)
   );

   assign pend = cause_q & mask_q;

   icc_prio #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_prio (
      .pend  (pend),
      .idx   (pend_idx),
      .valid (pend_valid)
   );

   if (OUT_REG) begin : g_out_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |pend;
      end
      assign irq_out = irq_q;
   end else begin : g_out_comb
      assign irq_out = |pend;
   end
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
   parameter int NUM_LINES = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter bit OUT_REG   = 1'b1,
   parameter int IDX_W     = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] src_level,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wr_data,
   input logic [NUM_LINES-1:0] cause_q,
   input logic [NUM_LINES-1:0] mask_q,
   input logic                 irq_out,
   input logic [IDX_W-1:0]     pend_idx,
   input logic                 pend_valid
);
   logic [NUM_LINES-1:0] pend_w;
   logic [NUM_LINES-1:0] below_w;
   logic                 cause_wr;
   logic                 mask_wr;

   assign pend_w   = cause_q & mask_q;
   assign below_w  = (NUM_LINES'(1) << pend_idx) - NUM_LINES'(1);
   assign cause_wr = wr_en && (addr == ADDR_W'(0));
   assign mask_wr  = wr_en && (addr == ADDR_W'(4));

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (cause_q == '0 && mask_q == '0));

   p_src_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_level != '0) |=> ((cause_q & $past(src_level)) == $past(src_level)));

   // R3 and R4: ack clears only lines whose source was low
   p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cause_wr |=> ((cause_q & $past(wr_data[NUM_LINES-1:0]) & ~$past(src_level)) == '0));

   p_src_beats_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_wr && ((wr_data[NUM_LINES-1:0] & src_level) != '0))
      |=> ((cause_q & $past(wr_data[NUM_LINES-1:0] & src_level))
           == $past(wr_data[NUM_LINES-1:0] & src_level)));

   p_mask_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_q == $past(wr_data[NUM_LINES-1:0])));

   p_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid == (pend_w != '0));

   p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (pend_w[pend_idx] && ((pend_w & below_w) == '0)));

   if (OUT_REG) begin : g_chk_reg
      p_out_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (irq_out == $past(pend_w != '0)));
   end

   p_stray_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cause_wr && !mask_wr) |=> ($stable(mask_q)
         && ((cause_q & ~$past(cause_q | src_level)) == '0)));
endmodule

bind irq_cause_hub icc_checker #(
   .NUM_LINES (NUM_LINES),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .OUT_REG   (OUT_REG),
   .IDX_W     (IDX_W)
) u_icc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_level  (src_level),
   .wr_en      (wr_en),
   .addr       (addr),
   .wr_data    (wr_data),
   .cause_q    (cause_q),
   .mask_q     (mask_q),
   .irq_out    (irq_out),
   .pend_idx   (pend_idx),
   .pend_valid (pend_valid)
);

// File: tb/sim_irq_cause_hub.sv
module sim_irq_cause_hub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_level = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq_out;
   logic [4:0]  pend_idx;
   logic        pend_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   string ph = "R1";

   logic [31:0] m_cause = '0;
   logic [31:0] m_mask = '0;
   logic        m_irq = 1'b0;

   always #2 clk = ~clk;

   irq_cause_hub u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_level  (src_level),
      .wr_en      (wr_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .irq_out    (irq_out),
      .pend_idx   (pend_idx),
      .pend_valid (pend_valid)
   );

   function automatic logic [4:0] f_lowest(logic [31:0] v);
      logic [4:0] r = '0;
      for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
      return r;
   endfunction

   function automatic logic [31:0] f_read(logic [3:0] a);
      if (a == 4'h0) return m_cause;
      if (a == 4'h4) return m_mask;
      return '0;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s (phase %s) actual=%h expected=%h", req, ph, act, exp);
      end
   endtask

   task automatic check_outputs();
      logic [31:0] p = m_cause & m_mask;
      string rq;
      chk(pend_valid == (p != 0), "R6", 32'(pend_valid), 32'(p != 0));
      if (p != 0) chk(pend_idx == f_lowest(p), "R7", 32'(pend_idx), 32'(f_lowest(p)));
      chk(irq_out == m_irq, "R8", 32'(irq_out), 32'(m_irq));
      rq = (addr == 4'h0) ? "R2" : (addr == 4'h4) ? "R5" : "R10";
      chk(rd_data == f_read(addr), rq, rd_data, f_read(addr));
   endtask

   // drive one cycle, update model at the edge, check after it
   task automatic cyc(logic [31:0] s, logic we, logic [3:0] a, logic [31:0] d);
      logic [31:0] clr;
      src_level = s; wr_en = we; addr = a; wr_data = d;
      @(posedge clk);
      clr = (we && a == 4'h0) ? d : '0;
      m_irq = ((m_cause & m_mask) != 0);
      m_cause = (m_cause & ~clr) | s;
      if (we && a == 4'h4) m_mask = d;
      #1;
      check_outputs();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog (phase %s) actual=%h expected=%h", ph, 32'd0, 32'd1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R1 reset state
      repeat (3) @(posedge clk);
      #1;
      chk(irq_out == 1'b0 && pend_valid == 1'b0, "R1", {irq_out, pend_valid}, 0);
      chk(rd_data == 0, "R1", rd_data, 0);
      rst_n = 1'b1;
      #1;
      chk(irq_out == 1'b0 && pend_valid == 1'b0, "R1", {irq_out, pend_valid}, 0);
      cyc('0, 1'b0, 4'h4, '0);
      chk(rd_data == 0, "R1", rd_data, 0);

      // R2 sources set cause; R5 mask write and readback
      ph = "R2";
      cyc(32'h0000_0028, 1'b0, 4'h0, '0);
      cyc('0, 1'b0, 4'h0, '0);
      ph = "R5";
      cyc('0, 1'b1, 4'h4, 32'hA5A5_0028);
      cyc('0, 1'b0, 4'h4, '0);
      // R7 priority: lines 3 and 5 pending, then higher only
      ph = "R7";
      cyc('0, 1'b0, 4'h0, '0);
      chk(pend_idx == 5'd3, "R7", 32'(pend_idx), 3);
      ph = "R3";
      cyc('0, 1'b1, 4'h0, 32'h0000_0008);
      chk(rd_data == 32'h20, "R3", rd_data, 32'h20);
      cyc('0, 1'b0, 4'h0, '0);
      chk(pend_idx == 5'd5, "R7", 32'(pend_idx), 5);
      // R4 collision: ack all while lines 0 and 31 held high
      ph = "R4";
      cyc(32'h8000_0001, 1'b1, 4'h0, 32'hFFFF_FFFF);
      chk(rd_data == 32'h8000_0001, "R4", rd_data, 32'h8000_0001);
      // R10 stray offsets
      ph = "R10";
      cyc('0, 1'b1, 4'h8, 32'hFFFF_FFFF);
      cyc('0, 1'b1, 4'hC, '0);
      cyc('0, 1'b0, 4'h4, '0);
      chk(rd_data == 32'hA5A5_0028, "R10", rd_data, 32'hA5A5_0028);
      // R9 quiesce
      ph = "R9";
      cyc('0, 1'b1, 4'h4, '0);
      cyc('0, 1'b1, 4'h0, 32'hFFFF_FFFF);
      chk(pend_valid == 1'b0, "R9", 32'(pend_valid), 0);
      cyc('0, 1'b0, 4'h0, '0);
      chk(irq_out == 1'b0 && rd_data == 0, "R9", {irq_out, rd_data[30:0]}, 0);

      // constrained random mix
      ph = "rand";
      for (int k = 0; k < 1500; k++) begin
         logic [31:0] s = $urandom & $urandom & $urandom & $urandom;
         logic [3:0]  a;
         int          r = $urandom_range(0, 9);
         a = (r < 4) ? 4'h0 : (r < 8) ? 4'h4 : 4'($urandom_range(0, 15));
         cyc(s, ($urandom_range(0, 2) == 0), a, $urandom);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule